// File: doc/BRIEF.md
# DRAM Training Pattern Engine

This block generates and checks data patterns while a memory controller is being trained. Software fills an internal pattern buffer one 32-bit word at a time. A pointer register selects the first word, and a data register stores each word and then moves the pointer forward by one. Software then sets a run length in 64-byte lines and a starting line address on the DRAM side. A write go bit streams the buffer out as 64-bit beats, eight beats to a line. A read go bit reads the same lines back and compares each returned beat with the buffer, byte lane by byte lane.

Every mismatching lane sets a bit in a failure mask that stays set until the next read run starts. Beats 0 to 3 of each line report into the primary mask and beats 4 to 7 into a secondary mask. Inverting a mask gives the per-lane pass map. Each go bit clears itself when its run is done, so software polls the control register for completion.

The sequencer has three states, named below with every transition:
- `S_IDLE`. It moves to `S_WRITE` on an accepted write go, or to `S_READ` on an accepted read go.
- `S_WRITE`. It issues one write beat per cycle and returns to `S_IDLE` after its last beat.
- `S_READ`. It issues one read request per cycle and compares responses as they arrive. It returns to `S_IDLE` on the edge that accepts the last response.

An empty run, with length zero, leaves either run state after one cycle.

Top module: `dram_train_engine`

## Requirements
- R1: After reset, every register reads 0, both go bits and both masks are 0, `busy` is 0 and no DRAM command is driven.
- R2: Register map, selected by `reg_addr`:

  | `reg_addr` | Register |
  |---|---|
  | 0 | control |
  | 1 | buffer word pointer |
  | 2 | buffer data |
  | 3 | target line, low part (14 bits) |
  | 4 | target line, high part (2 bits) |
  | 5 | primary fail mask |
  | 6 | secondary fail mask |

  Control bits: bit 0 enables write mode, bit 1 enables read mode, bit 2 is write go, bit 3 is read go, and bits 11:8 hold the length in lines. The target line is {high[1:0], low[13:0]}. Every other read-back bit is 0.
- R3: A write to the data register stores the word at the pointer. The pointer then advances by one and wraps modulo 64. Word 2k fills bits 31:0 of buffer beat k and word 2k+1 fills bits 63:32.
- R4: An accepted write go issues length×8 write beats on consecutive cycles. Beat k carries buffer beat k mod 32, on line target + k/8 and beat index k mod 8.
- R5: The write go bit reads 1 for exactly length×8 cycles after the accepting edge, then clears by itself.
- R6: An accepted read go issues length×8 read requests with the same line and beat addressing. The read go bit clears on the edge that accepts the last response.
- R7: Response j is compared with buffer beat j mod 32. A mismatch in byte lane L sets bit L of the primary mask when j mod 8 < 4 and of the secondary mask otherwise. Mask bits 31:8 read 0.
- R8: Mask bits are sticky for the whole read run and are cleared only when a read go is accepted.
- R9: A go bit written while its mode bit in the same write is 0 is ignored. When both go bits are accepted together, only the write run starts.
- R10: While a run is in progress, register writes have no effect.
- R11: With length 0, a go bit reads 1 for one cycle and no DRAM command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational on reg_addr) |
| dram_wr_en | output | 1 | write beat valid |
| dram_rd_en | output | 1 | read request valid |
| dram_line | output | 16 | DRAM line address of the beat |
| dram_beat | output | 3 | beat index within the line |
| dram_wdata | output | 64 | write beat data |
| dram_rvalid | input | 1 | read response valid, in request order |
| dram_rdata | input | 64 | read response data |
| fail_mask_a | output | 8 | primary per-lane failure mask |
| fail_mask_b | output | 8 | secondary per-lane failure mask |
| busy | output | 1 | a run is in progress |

## Verification
- Write go: after the accepting edge, the go bit is due to stay high for length×8 cycles.
- Read go: the go bit stays high for length×8 cycles plus the two-cycle latency of the bench's memory model.
- How cycles are counted: the bench polls the control register at falling edges and counts the cycles, so each count lands on a settled value.
- Fail masks: the masks are read only after the go bit reads 0, when the final response has already been registered.
- Sweep: the bench corrupts one bit in every lane at every beat position of a two-line run. It works out from the lane and beat which mask should carry the failure.

// File: rtl/trn_pkg.sv
package trn_pkg;

    localparam int BEATS_PER_LINE = 8;
    localparam int LANES          = 8;

    typedef enum logic [2:0] {
        REG_CTRL    = 3'd0,
        REG_BUFPTR  = 3'd1,
        REG_BUFDATA = 3'd2,
        REG_TGT_LO  = 3'd3,
        REG_TGT_HI  = 3'd4,
        REG_FAIL_A  = 3'd5,
        REG_FAIL_B  = 3'd6
    } reg_sel_e;

    localparam int CTL_WMODE = 0;
    localparam int CTL_RMODE = 1;
    localparam int CTL_WGO   = 2;
    localparam int CTL_RGO   = 3;
    localparam int CTL_LEN   = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_READ  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/trn_pattern_buf.sv
module trn_pattern_buf #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             ld_en,
    input  logic [PTR_W-1:0] ld_ptr,
    input  logic [31:0]      ld_data,
    input  logic [IDX_W-1:0] idx_a,
    output logic [63:0]      q_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [63:0]      q_b
);

    logic [63:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            if (ld_ptr[0]) store[ld_ptr[PTR_W-1:1]][63:32] <= ld_data;
            else           store[ld_ptr[PTR_W-1:1]][31:0]  <= ld_data;
        end
    end

    assign q_a = store[idx_a];
    assign q_b = store[idx_b];

endmodule

// File: rtl/trn_lane_cmp.sv
module trn_lane_cmp #(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               upper_half,
    input  logic [LANES*8-1:0] expect_d,
    input  logic [LANES*8-1:0] actual_d,
    output logic [LANES-1:0]   fail_a,
    output logic [LANES-1:0]   fail_b
);

    logic [LANES-1:0] lane_bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bad[g] = (expect_d[g*8 +: 8] != actual_d[g*8 +: 8]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail_a <= '0;
            fail_b <= '0;
        end else if (en) begin
            if (upper_half) fail_b <= fail_b | lane_bad;
            else            fail_a <= fail_a | lane_bad;
        end
    end

endmodule

// File: rtl/trn_seq.sv
module trn_seq
    import trn_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             start_rd,
    input  logic [CNT_W-1:0] total,
    input  logic             rsp_valid,
    output logic [CNT_W-1:0] iss_cnt,
    output logic [CNT_W-1:0] rsp_cnt,
    output logic             wr_go,
    output logic             rd_go,
    output logic             cmd_wr,
    output logic             cmd_rd,
    output logic             cmp_en,
    output logic             clr_status
);

    seq_state_e state_q, state_d;
    logic       wr_last, rd_last;

    assign wr_last = (total == '0) || (iss_cnt == total - CNT_W'(1));
    assign rd_last = (total == '0) || (rsp_valid && rsp_cnt == total - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_wr)     state_d = S_WRITE;
                     else if (start_rd) state_d = S_READ;
            S_WRITE: if (wr_last)      state_d = S_IDLE;
            S_READ:  if (rd_last)      state_d = S_IDLE;
            default:                   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_go      = (state_q == S_WRITE);
        rd_go      = (state_q == S_READ);
        cmd_wr     = (state_q == S_WRITE) && (total != '0);
        cmd_rd     = (state_q == S_READ) && (iss_cnt < total);
        cmp_en     = (state_q == S_READ) && rsp_valid;
        clr_status = (state_q == S_IDLE) && (state_d == S_READ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_IDLE) begin
            iss_cnt <= '0;
            rsp_cnt <= '0;
        end else begin
            if (cmd_wr || cmd_rd) iss_cnt <= iss_cnt + CNT_W'(1);
            if (cmp_en)           rsp_cnt <= rsp_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dram_train_engine.sv
module dram_train_engine
    import trn_pkg::*;
#(
    parameter int BUF_LINES = 4,
    parameter int LEN_W     = 4,
    parameter int LO_W      = 14,
    localparam int BUF_BEATS = BUF_LINES * BEATS_PER_LINE,
    localparam int BIDX_W    = $clog2(BUF_BEATS),
    localparam int PTR_W     = BIDX_W + 1,
    localparam int CNT_W     = LEN_W + 3,
    localparam int LINE_AW   = LO_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               dram_wr_en,
    output logic               dram_rd_en,
    output logic [LINE_AW-1:0] dram_line,
    output logic [2:0]         dram_beat,
    output logic [63:0]        dram_wdata,
    input  logic               dram_rvalid,
    input  logic [63:0]        dram_rdata,
    output logic [7:0]         fail_mask_a,
    output logic [7:0]         fail_mask_b,
    output logic               busy
);

    logic             mode_wr_q, mode_rd_q;
    logic [LEN_W-1:0] len_q;
    logic [PTR_W-1:0] bufptr_q;
    logic [LO_W-1:0]  tgt_lo_q;
    logic [1:0]       tgt_hi_q;

    logic             wr_go, rd_go, cmp_en, clr_status;
    logic [CNT_W-1:0] iss_cnt, rsp_cnt, total;
    logic             acc, ctl_wr, start_wr, start_rd;
    logic [63:0]      exp_beat;

    assign busy   = wr_go || rd_go;
    assign acc    = reg_wr && !busy;
    assign ctl_wr = acc && (reg_addr == REG_CTRL);
    assign total  = {len_q, 3'b000};

    assign start_wr = ctl_wr && reg_wdata[CTL_WMODE] && reg_wdata[CTL_WGO];
    assign start_rd = ctl_wr && reg_wdata[CTL_RMODE] && reg_wdata[CTL_RGO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_wr_q <= 1'b0;
            mode_rd_q <= 1'b0;
            len_q     <= '0;
            bufptr_q  <= '0;
            tgt_lo_q  <= '0;
            tgt_hi_q  <= '0;
        end else if (acc) begin
            unique case (reg_addr)
                REG_CTRL: begin
                    mode_wr_q <= reg_wdata[CTL_WMODE];
                    mode_rd_q <= reg_wdata[CTL_RMODE];
                    len_q     <= reg_wdata[CTL_LEN +: LEN_W];
                end
                REG_BUFPTR:  bufptr_q <= reg_wdata[PTR_W-1:0];
                REG_BUFDATA: bufptr_q <= bufptr_q + PTR_W'(1);
                REG_TGT_LO:  tgt_lo_q <= reg_wdata[LO_W-1:0];
                REG_TGT_HI:  tgt_hi_q <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    trn_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .total      (total),
        .rsp_valid  (dram_rvalid),
        .iss_cnt    (iss_cnt),
        .rsp_cnt    (rsp_cnt),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .cmd_wr     (dram_wr_en),
        .cmd_rd     (dram_rd_en),
        .cmp_en     (cmp_en),
        .clr_status (clr_status)
    );

    trn_pattern_buf #(.DEPTH(BUF_BEATS)) u_buf (
        .clk     (clk),
        .ld_en   (acc && reg_addr == REG_BUFDATA),
        .ld_ptr  (bufptr_q),
        .ld_data (reg_wdata),
        .idx_a   (iss_cnt[BIDX_W-1:0]),
        .q_a     (dram_wdata),
        .idx_b   (rsp_cnt[BIDX_W-1:0]),
        .q_b     (exp_beat)
    );

    trn_lane_cmp #(.LANES(LANES)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_status),
        .en         (cmp_en),
        .upper_half (rsp_cnt[2]),
        .expect_d   (exp_beat),
        .actual_d   (dram_rdata),
        .fail_a     (fail_mask_a),
        .fail_b     (fail_mask_b)
    );

    assign dram_line = {tgt_hi_q, tgt_lo_q} + LINE_AW'(iss_cnt[CNT_W-1:3]);
    assign dram_beat = iss_cnt[2:0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL:   reg_rdata = 32'({len_q, 4'b0000, rd_go, wr_go, mode_rd_q, mode_wr_q});
            REG_BUFPTR: reg_rdata = 32'(bufptr_q);
            REG_TGT_LO: reg_rdata = 32'(tgt_lo_q);
            REG_TGT_HI: reg_rdata = 32'(tgt_hi_q);
            REG_FAIL_A: reg_rdata = 32'(fail_mask_a);
            REG_FAIL_B: reg_rdata = 32'(fail_mask_b);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/trn_checker.sv
module trn_checker #(
    parameter int LINE_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_go,
    input logic               rd_go,
    input logic               mode_wr,
    input logic               mode_rd,
    input logic               dram_wr_en,
    input logic               dram_rd_en,
    input logic [LINE_AW-1:0] dram_line,
    input logic [2:0]         dram_beat,
    input logic [7:0]         fail_a,
    input logic [7:0]         fail_b
);

    // R9
    go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_go, rd_go}));

    // R9
    wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_wr_en |-> mode_wr);

    // R9
    rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dram_rd_en |-> mode_rd);

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_wr_en && $past(dram_wr_en)) |-> (dram_beat == $past(dram_beat) + 3'd1));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_wr_en && $past(dram_wr_en) && dram_beat == 3'd0)
            |-> (dram_line == $past(dram_line) + LINE_AW'(1)));

    // R8
    sticky_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ((fail_a & $past(fail_a)) == $past(fail_a)));

    // R8
    sticky_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ((fail_b & $past(fail_b)) == $past(fail_b)));

endmodule

bind dram_train_engine trn_checker #(.LINE_AW(LINE_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .mode_wr    (mode_wr_q),
    .mode_rd    (mode_rd_q),
    .dram_wr_en (dram_wr_en),
    .dram_rd_en (dram_rd_en),
    .dram_line  (dram_line),
    .dram_beat  (dram_beat),
    .fail_a     (fail_mask_a),
    .fail_b     (fail_mask_b)
);

// File: tb/dram_train_engine_test.sv
module dram_train_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dram_wr_en, dram_rd_en;
    logic [15:0] dram_line;
    logic [2:0]  dram_beat;
    logic [63:0] dram_wdata;
    logic        dram_rvalid = 1'b0;
    logic [63:0] dram_rdata = 64'd0;
    logic [7:0]  fail_mask_a, fail_mask_b;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_train_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dram_wr_en(dram_wr_en), .dram_rd_en(dram_rd_en),
        .dram_line(dram_line), .dram_beat(dram_beat), .dram_wdata(dram_wdata),
        .dram_rvalid(dram_rvalid), .dram_rdata(dram_rdata),
        .fail_mask_a(fail_mask_a), .fail_mask_b(fail_mask_b), .busy(busy)
    );

    // memory model: 32 lines x 8 beats, read latency 2, optional bit flips
    logic [63:0] mem [256];
    logic        p1_v = 1'b0;
    logic [63:0] p1_d = 64'd0;
    logic        inj_a_en = 1'b0, inj_b_en = 1'b0;
    logic [7:0]  inj_a_key = 8'd0, inj_b_key = 8'd0;
    logic [63:0] inj_a_msk = 64'd0, inj_b_msk = 64'd0;
    int          wr_beats = 0, rd_reqs = 0;
    logic [15:0] last_wr_line = 16'd0;

    always @(posedge clk) begin
        logic [7:0]  k;
        logic [63:0] d;
        k = {dram_line[4:0], dram_beat};
        if (dram_wr_en) begin
            mem[k] <= dram_wdata;
            wr_beats <= wr_beats + 1;
            last_wr_line <= dram_line;
        end
        d = mem[k];
        if (inj_a_en && k == inj_a_key) d = d ^ inj_a_msk;
        if (inj_b_en && k == inj_b_key) d = d ^ inj_b_msk;
        if (dram_rd_en) rd_reqs <= rd_reqs + 1;
        p1_v        <= dram_rd_en;
        p1_d        <= d;
        dram_rvalid <= p1_v;
        dram_rdata  <= p1_d;
    end

    function automatic logic [31:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h3C, ~b, b + 8'h11, 8'(b * 8'd7)};
    endfunction

    function automatic logic [63:0] beat_exp(input int k);
        return {pat(2*k + 1), pat(2*k)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // counts cycles during which a go bit reads 1 after the accepting edge
    task automatic run(input logic [31:0] ctl, output int cyc);
        logic [31:0] v;
        bit done = 0;
        reg_write(3'd0, ctl);
        cyc = 0;
        while (!done) begin
            reg_read(3'd0, v);
            if (v[3:2] == 2'b00) done = 1;
            else begin
                cyc++;
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc, wb0, rr0;
        for (int i = 0; i < 256; i++) mem[i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            reg_read(3'(a), v);
            chk("R1 reg", 64'(v), 64'd0);
        end
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 cmds", 64'({dram_wr_en, dram_rd_en}), 64'd0);
        chk("R1 masks", 64'({fail_mask_a, fail_mask_b}), 64'd0);

        // R3 load full buffer, pointer wraps to 0
        reg_write(3'd1, 32'd0);
        for (int i = 0; i < 64; i++) reg_write(3'd2, pat(i));
        reg_read(3'd1, v);
        chk("R3 ptr wrap after 64", 64'(v), 64'd0);
        reg_write(3'd1, 32'd62);
        reg_write(3'd2, pat(62));
        reg_write(3'd2, pat(63));
        reg_write(3'd2, pat(0));
        reg_read(3'd1, v);
        chk("R3 ptr wrap from 62", 64'(v), 64'd1);

        // R2 target line setup
        reg_write(3'd3, 32'd8);
        reg_write(3'd4, 32'd0);
        reg_read(3'd3, v);
        chk("R2 tgt lo", 64'(v), 64'd8);

        // R4 R5 write run of 2 lines
        wb0 = wr_beats;
        run(32'h205, cyc);
        chk("R5 wgo cycles", 64'(cyc), 64'd16);
        chk("R4 beat count", 64'(wr_beats - wb0), 64'd16);
        for (int k = 0; k < 16; k++)
            chk("R4 written data", mem[8*8 + k], beat_exp(k));
        reg_read(3'd0, v);
        chk("R2 ctrl readback", 64'(v), 64'h201);

        // R6 R7 clean read
        rr0 = rd_reqs;
        run(32'h20A, cyc);
        chk("R6 rgo cycles", 64'(cyc), 64'd18);
        chk("R6 req count", 64'(rd_reqs - rr0), 64'd16);
        reg_read(3'd5, v); chk("R7 clean A", 64'(v), 64'd0);
        reg_read(3'd6, v); chk("R7 clean B", 64'(v), 64'd0);

        // R7 sweep: one flipped bit per lane per beat position
        for (int lane = 0; lane < 8; lane++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                inj_a_en  = 1'b1;
                inj_a_key = 8'((8 + j/8) * 8 + j % 8);
                inj_a_msk = 64'd1 << (8*lane + j % 8);
                run(32'h20A, cyc);
                reg_read(3'd5, v);
                chk("R7 sweep A", 64'(v), (j % 8 < 4) ? 64'(1 << lane) : 64'd0);
                reg_read(3'd6, v);
                chk("R7 sweep B", 64'(v), (j % 8 >= 4) ? 64'(1 << lane) : 64'd0);
            end
        end

        // R8 two failures in one run accumulate, then clear on next start
        @(negedge clk);
        inj_a_en = 1'b1; inj_a_key = 8'(8*8 + 1);  inj_a_msk = 64'hFF << 16;
        inj_b_en = 1'b1; inj_b_key = 8'(9*8 + 2);  inj_b_msk = 64'h01 << 40;
        run(32'h20A, cyc);
        reg_read(3'd5, v);
        chk("R8 sticky A", 64'(v), 64'h24);
        @(negedge clk);
        inj_a_en = 1'b0; inj_b_en = 1'b0;
        run(32'h20A, cyc);
        reg_read(3'd5, v);
        chk("R8 cleared on start", 64'(v), 64'd0);

        // R9 go without mode ignored
        wb0 = wr_beats;
        reg_write(3'd0, 32'h104);
        reg_read(3'd0, v);
        chk("R9 wgo no mode", 64'(v[3:2]), 64'd0);
        repeat (4) @(negedge clk);
        chk("R9 no beats", 64'(wr_beats - wb0), 64'd0);
        rr0 = rd_reqs;
        reg_write(3'd0, 32'h109);
        reg_read(3'd0, v);
        chk("R9 rgo no mode", 64'(v[3:2]), 64'd0);
        repeat (4) @(negedge clk);
        chk("R9 no reads", 64'(rd_reqs - rr0), 64'd0);

        // R9 both go bits: write wins
        wb0 = wr_beats; rr0 = rd_reqs;
        run(32'h10F, cyc);
        chk("R9 both: writes", 64'(wr_beats - wb0), 64'd8);
        chk("R9 both: reads", 64'(rd_reqs - rr0), 64'd0);

        // R4 line composition with high part
        reg_write(3'd4, 32'd2);
        reg_write(3'd3, 32'd3);
        run(32'h105, cyc);
        chk("R4 hi line", 64'(last_wr_line), 64'h8003);
        reg_write(3'd4, 32'd0);

        // R4 buffer wraps past 4 lines, R10 writes during run ignored
        reg_write(3'd3, 32'd16);
        reg_write(3'd0, 32'h505);
        reg_write(3'd3, 32'h123);
        reg_write(3'd0, 32'h305);
        run(32'h0, cyc);
        reg_read(3'd3, v);
        chk("R10 tgt held", 64'(v), 64'd16);
        reg_read(3'd0, v);
        chk("R10 ctrl held", 64'(v), 64'h501);
        for (int b = 0; b < 8; b++)
            chk("R4 wrap line 4", mem[20*8 + b], beat_exp(b));

        // R11 zero length
        wb0 = wr_beats;
        run(32'h005, cyc);
        chk("R11 go cycles", 64'(cyc), 64'd1);
        chk("R11 no beats", 64'(wr_beats - wb0), 64'd0);
        rr0 = rd_reqs;
        run(32'h00A, cyc);
        chk("R11 read cycles", 64'(cyc), 64'd1);
        chk("R11 no reads", 64'(rd_reqs - rr0), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule